// File: doc/BRIEF.md
# Multiple-Register Transfer Sequencer

This block runs one load-multiple or store-multiple operation between a sixteen-entry, 32-bit register file and memory. A single start pulse supplies the operation: direction, a sixteen-bit register mask, the index of the base register, one of four address-stepping modes, a writeback flag, the encoding form and the branch state settings. The sequencer then emits one memory request per selected register. Registers are visited from the lowest index to the highest, and the lowest index always takes the lowest address. Each request uses a valid/ready handshake. A load waits for its response before it issues the next request.

The register file sits outside the block. The block reads it through one combinational read port and writes it through one write port. On a load, the block writes the register when the memory response arrives. If writeback is selected, one extra cycle puts the final address into the base register. When register 15 is loaded, the block outputs a branch target with bit 0 cleared and the new instruction state. Bit 0 of the loaded word gives that state, unless state switching is disabled. Operations that break the encoding rules are rejected with an error pulse and perform no transfers.

Top module: `xfer_multi_seq`

## Requirements
- R1: An operation with an all-zero mask is rejected. The `err` output is high for exactly the cycle after the start pulse, `busy` stays low, and no request is issued.
- R2: An operation whose base index is 15 is rejected in the same way as R1.
- R3: With `enc_form` = 1 (narrow 32-bit form), three masks are rejected: any mask containing register 13, a store mask containing register 15, and a load mask containing both 14 and 15.
- R4: With `enc_form` = 2 (short form), the operation is rejected in each of these cases: a mask bit above 7 is set, the base index is above 7, the mode is not 0, or writeback is 0. The value `enc_form` = 3 is always rejected.
- R5: Requests name the set mask bits in ascending order. The first address depends on `addr_mode`, where N is the number of set bits: 0 (increment-after) gives base; 1 (increment-before) gives base+4; 2 (decrement-after) gives base−4N+4; 3 (decrement-before) gives base−4N.
- R6: Each accepted request is followed by a next request whose address is 4 higher.
- R7: With writeback set, one cycle after the last transfer completes, the register file receives a write of base−4N (modes 2 and 3) or base+4N (modes 0 and 1) to the base register. Without writeback, the base register is never written.
- R8: Store data comes from the register file. When a store with writeback lists the base register as its lowest set bit, the word stored for it is the base value from before the operation.
- R9: A load writes the register file only in a cycle where `mem_rsp_valid` is high. It writes the response data to the register named by the accepted request.
- R10: A load response for register 15 also drives `br_valid`, with `br_target` equal to the data with bit 0 cleared. `br_compact` equals data bit 0, or `cur_compact` when `state_sw_dis` is 1.
- R11: `busy` rises the cycle after an accepted start pulse. It falls only after the last transfer and, if selected, the writeback. Start pulses while busy are ignored and raise no error.
- R12: While `mem_req_valid` is high and `mem_req_ready` is low, the request stays valid with unchanged address and register index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, sampled while idle |
| is_load | input | 1 | 1 selects load, 0 selects store |
| reg_mask | input | 16 | Registers to transfer |
| base_idx | input | 4 | Base register index |
| addr_mode | input | 2 | 0 inc-after, 1 inc-before, 2 dec-after, 3 dec-before |
| wback | input | 1 | Write the final address to the base register |
| enc_form | input | 2 | 0 full, 1 narrow 32-bit, 2 short, 3 reserved |
| state_sw_dis | input | 1 | Disables the state change taken from loaded bit 0 |
| cur_compact | input | 1 | Present instruction state, kept when switching is disabled |
| busy | output | 1 | Operation in progress |
| err | output | 1 | One-cycle illegal-operation pulse |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | Request is a store |
| mem_req_addr | output | 32 | Word address of the beat |
| mem_req_wdata | output | 32 | Store data |
| mem_req_reg | output | 4 | Register index of the beat |
| mem_rsp_valid | input | 1 | Load data valid |
| mem_rsp_data | input | 32 | Load data |
| rf_raddr | output | 4 | Register file read index |
| rf_rdata | input | 32 | Register file read data (combinational) |
| rf_we | output | 1 | Register file write enable |
| rf_waddr | output | 4 | Register file write index |
| rf_wdata | output | 32 | Register file write data |
| br_valid | output | 1 | Register 15 was loaded |
| br_target | output | 32 | Branch target, bit 0 cleared |
| br_compact | output | 1 | Instruction state after the branch |

## Verification
The error pulse and the rise of `busy` are due one clock after the start edge. The bench samples both at the next falling edge. Request fields, the load write, the branch outputs and the writeback are combinational from state and the inputs of the current cycle. The bench therefore drives ready and response at a falling edge and checks one time unit later, in the same cycle. It counts a beat only when valid and ready are both high there. In that same sampling window the bench expects the base write in the cycle after the last handshake or response, and expects `busy` low in the cycle after that.

// File: rtl/xfer_pkg.sv
package xfer_pkg;

    localparam int NREG        = 16;
    localparam int RIDX_W      = $clog2(NREG);
    localparam int CNT_W       = $clog2(NREG + 1);
    localparam int XLEN        = 32;
    localparam int WORD_BYTES  = 4;
    localparam int PC_IDX      = NREG - 1;
    localparam int LR_IDX      = NREG - 2;
    localparam int SP_IDX      = NREG - 3;
    localparam int SHORT_NREG  = 8;

    typedef logic [NREG-1:0]   reg_mask_t;
    typedef logic [RIDX_W-1:0] reg_idx_t;
    typedef logic [CNT_W-1:0]  reg_cnt_t;
    typedef logic [XLEN-1:0]   word_t;

    typedef enum logic [1:0] {
        AM_INC_AFTER  = 2'd0,
        AM_INC_BEFORE = 2'd1,
        AM_DEC_AFTER  = 2'd2,
        AM_DEC_BEFORE = 2'd3
    } addr_mode_e;

    typedef enum logic [1:0] {
        FORM_FULL     = 2'd0,
        FORM_NARROW   = 2'd1,
        FORM_SHORT    = 2'd2,
        FORM_RESERVED = 2'd3
    } enc_form_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_REQ,
        ST_RSP,
        ST_WB
    } seq_state_e;

    typedef struct packed {
        logic     is_load;
        logic     wback;
        reg_idx_t base;
        word_t    wb_addr;
        logic     keep_state;
        logic     state_now;
    } op_ctx_t;

    function automatic reg_cnt_t mask_popcount(input reg_mask_t m);
        reg_cnt_t c;
        c = '0;
        for (int i = 0; i < NREG; i++) begin
            c = c + reg_cnt_t'(m[i]);
        end
        return c;
    endfunction

    function automatic reg_mask_t idx_bit(input reg_idx_t idx);
        return reg_mask_t'(1) << idx;
    endfunction

endpackage

// File: rtl/xfer_legal_chk.sv
module xfer_legal_chk
    import xfer_pkg::*;
(
    input  logic      is_load,
    input  reg_mask_t mask,
    input  reg_idx_t  base,
    input  logic [1:0] mode,
    input  logic      wback,
    input  logic [1:0] form,
    output logic      illegal
);
    localparam int HI_W = NREG - SHORT_NREG;

    logic generic_bad;
    logic narrow_bad;
    logic short_bad;
    logic [HI_W-1:0] hi_bits;

    assign hi_bits = mask[NREG-1:SHORT_NREG];

    always_comb begin
        generic_bad = (mask == '0) || (base == reg_idx_t'(PC_IDX));

        narrow_bad = mask[SP_IDX]
                  || (!is_load && mask[PC_IDX])
                  || (is_load && mask[PC_IDX] && mask[LR_IDX]);

        short_bad = (hi_bits != '0)
                 || (base >= reg_idx_t'(SHORT_NREG))
                 || (addr_mode_e'(mode) != AM_INC_AFTER)
                 || !wback;

        unique case (enc_form_e'(form))
            FORM_FULL:     illegal = generic_bad;
            FORM_NARROW:   illegal = generic_bad || narrow_bad;
            FORM_SHORT:    illegal = generic_bad || short_bad;
            default:       illegal = 1'b1;
        endcase
    end

endmodule

// File: rtl/xfer_addr_plan.sv
module xfer_addr_plan
    import xfer_pkg::*;
(
    input  word_t      base_val,
    input  reg_cnt_t   count,
    input  logic [1:0] mode,
    output word_t      first_addr,
    output word_t      final_addr
);
    localparam word_t STEP = word_t'(WORD_BYTES);
    localparam int    STEP_SH = $clog2(WORD_BYTES);

    word_t span;
    word_t low_end;

    assign span    = word_t'(count) << STEP_SH;
    assign low_end = base_val - span;

    always_comb begin
        unique case (addr_mode_e'(mode))
            AM_INC_AFTER:  first_addr = base_val;
            AM_INC_BEFORE: first_addr = base_val + STEP;
            AM_DEC_AFTER:  first_addr = low_end + STEP;
            default:       first_addr = low_end;
        endcase
        final_addr = mode[1] ? low_end : (base_val + span);
    end

endmodule

// File: rtl/xfer_lowest_pick.sv
module xfer_lowest_pick
    import xfer_pkg::*;
#(
    parameter int N = NREG,
    localparam int W = $clog2(N)
) (
    input  logic [N-1:0] pick_in,
    output logic [W-1:0] pick_idx
);
    always_comb begin
        logic found;
        found    = 1'b0;
        pick_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (!found && pick_in[i]) begin
                pick_idx = W'(i);
                found    = 1'b1;
            end
        end
    end

    // R5: the chosen index is set and nothing below it is set
    always_comb begin
        if (pick_in != '0) begin
            a_pick_lowest_r5: assert (pick_in[pick_idx] &&
                ((pick_in & ((N'(1) << pick_idx) - N'(1))) == '0));
        end
    end

endmodule

// File: rtl/xfer_multi_seq.sv
module xfer_multi_seq
    import xfer_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic            is_load,
    input  logic [NREG-1:0] reg_mask,
    input  logic [RIDX_W-1:0] base_idx,
    input  logic [1:0]      addr_mode,
    input  logic            wback,
    input  logic [1:0]      enc_form,
    input  logic            state_sw_dis,
    input  logic            cur_compact,
    output logic            busy,
    output logic            err,
    output logic            mem_req_valid,
    input  logic            mem_req_ready,
    output logic            mem_req_write,
    output logic [XLEN-1:0] mem_req_addr,
    output logic [XLEN-1:0] mem_req_wdata,
    output logic [RIDX_W-1:0] mem_req_reg,
    input  logic            mem_rsp_valid,
    input  logic [XLEN-1:0] mem_rsp_data,
    output logic [RIDX_W-1:0] rf_raddr,
    input  logic [XLEN-1:0] rf_rdata,
    output logic            rf_we,
    output logic [RIDX_W-1:0] rf_waddr,
    output logic [XLEN-1:0] rf_wdata,
    output logic            br_valid,
    output logic [XLEN-1:0] br_target,
    output logic            br_compact
);
    localparam word_t STEP = word_t'(WORD_BYTES);

    seq_state_e state;
    reg_mask_t  pend_mask;
    word_t      cur_addr;
    reg_idx_t   ld_reg;
    op_ctx_t    ctx;
    logic       err_q;

    logic       bad_op;
    reg_cnt_t   op_count;
    word_t      first_addr;
    word_t      final_addr;
    reg_idx_t   cur_reg;
    reg_mask_t  rest_mask;
    seq_state_e after_last;

    assign op_count = mask_popcount(reg_mask);

    xfer_legal_chk u_legal (
        .is_load (is_load),
        .mask    (reg_mask),
        .base    (base_idx),
        .mode    (addr_mode),
        .wback   (wback),
        .form    (enc_form),
        .illegal (bad_op)
    );

    xfer_addr_plan u_addr (
        .base_val   (rf_rdata),
        .count      (op_count),
        .mode       (addr_mode),
        .first_addr (first_addr),
        .final_addr (final_addr)
    );

    xfer_lowest_pick #(.N(NREG)) u_pick (
        .pick_in  (pend_mask),
        .pick_idx (cur_reg)
    );

    assign rest_mask  = pend_mask & ~idx_bit(cur_reg);
    assign after_last = ctx.wback ? ST_WB : ST_IDLE;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            pend_mask <= '0;
            cur_addr  <= '0;
            ld_reg    <= '0;
            ctx       <= '0;
            err_q     <= 1'b0;
        end else begin
            err_q <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        if (bad_op) begin
                            err_q <= 1'b1;
                        end else begin
                            state          <= ST_REQ;
                            pend_mask      <= reg_mask;
                            cur_addr       <= first_addr;
                            ctx.is_load    <= is_load;
                            ctx.wback      <= wback;
                            ctx.base       <= base_idx;
                            ctx.wb_addr    <= final_addr;
                            ctx.keep_state <= state_sw_dis;
                            ctx.state_now  <= cur_compact;
                        end
                    end
                end
                ST_REQ: begin
                    if (mem_req_ready) begin
                        cur_addr  <= cur_addr + STEP;
                        pend_mask <= rest_mask;
                        ld_reg    <= cur_reg;
                        if (ctx.is_load) begin
                            state <= ST_RSP;
                        end else if (rest_mask == '0) begin
                            state <= after_last;
                        end
                    end
                end
                ST_RSP: begin
                    if (mem_rsp_valid) begin
                        state <= (pend_mask == '0) ? after_last : ST_REQ;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy          = (state != ST_IDLE);
    assign err           = err_q;
    assign mem_req_valid = (state == ST_REQ);
    assign mem_req_write = !ctx.is_load;
    assign mem_req_addr  = cur_addr;
    assign mem_req_reg   = cur_reg;
    assign mem_req_wdata = rf_rdata;
    assign rf_raddr      = (state == ST_IDLE) ? base_idx : cur_reg;

    always_comb begin
        rf_we    = 1'b0;
        rf_waddr = ld_reg;
        rf_wdata = mem_rsp_data;
        if (state == ST_RSP && mem_rsp_valid) begin
            rf_we = 1'b1;
        end else if (state == ST_WB) begin
            rf_we    = 1'b1;
            rf_waddr = ctx.base;
            rf_wdata = ctx.wb_addr;
        end
    end

    assign br_valid   = (state == ST_RSP) && mem_rsp_valid && (ld_reg == reg_idx_t'(PC_IDX));
    assign br_target  = {mem_rsp_data[XLEN-1:1], 1'b0};
    assign br_compact = ctx.keep_state ? ctx.state_now : mem_rsp_data[0];

    // R12: a stalled request holds its fields
    p_req_hold_r12: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && !mem_req_ready |=>
            mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_reg));

    // R6: a following request is one word higher
    p_addr_step_r6: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && mem_req_ready |=>
            !mem_req_valid || (mem_req_addr == $past(mem_req_addr) + STEP));

    // R1: an error pulse follows a start and leaves the block idle
    p_err_idle_r1: assert property (@(posedge clk) disable iff (rst)
        err |-> !busy && !mem_req_valid && $past(start));

    // R11: busy only rises after a start pulse
    p_busy_rise_r11: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));

    // R9: no register write while a load response is awaited
    p_rsp_write_r9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RSP) && !mem_rsp_valid |-> !rf_we);

endmodule

// File: tb/test_xfer_multi_seq.sv
module test_xfer_multi_seq;
    import xfer_pkg::*;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst, start, is_load, wback, state_sw_dis, cur_compact;
    logic [15:0] reg_mask;
    logic [3:0]  base_idx;
    logic [1:0]  addr_mode, enc_form;
    logic busy, err, mem_req_valid, mem_req_ready, mem_req_write;
    logic [31:0] mem_req_addr, mem_req_wdata, mem_rsp_data, rf_rdata, rf_wdata, br_target;
    logic [3:0]  mem_req_reg, rf_raddr, rf_waddr;
    logic mem_rsp_valid, rf_we, br_valid, br_compact;

    xfer_multi_seq i_xfer_multi_seq (
        .clk(clk), .rst(rst), .start(start), .is_load(is_load), .reg_mask(reg_mask),
        .base_idx(base_idx), .addr_mode(addr_mode), .wback(wback), .enc_form(enc_form),
        .state_sw_dis(state_sw_dis), .cur_compact(cur_compact), .busy(busy), .err(err),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata), .mem_req_reg(mem_req_reg),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .rf_we(rf_we), .rf_waddr(rf_waddr),
        .rf_wdata(rf_wdata), .br_valid(br_valid), .br_target(br_target),
        .br_compact(br_compact)
    );

    logic [31:0] rf_mem [16];
    logic [31:0] exp_rf [16];
    assign rf_rdata = rf_mem[rf_raddr];
    always @(posedge clk) if (rf_we) rf_mem[rf_waddr] <= rf_wdata;

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] memfn(input logic [31:0] a);
        return (a * 32'h9E37_79B1) ^ 32'h0F0F_3C3C ^ (a >> 3);
    endfunction

    function automatic bit exp_bad(input bit ld, input logic [15:0] m, input logic [3:0] b,
                                   input logic [1:0] md, input bit wb, input logic [1:0] f);
        bit bad;
        bad = (m == 16'h0) || (b == 4'd15);
        if (f == 2'd1) bad = bad || m[13] || (!ld && m[15]) || (ld && m[14] && m[15]);
        if (f == 2'd2) bad = bad || (m[15:8] != 8'h0) || (b > 4'd7) || (md != 2'd0) || !wb;
        if (f == 2'd3) bad = 1'b1;
        return bad;
    endfunction

    task automatic run_op(input bit ld, input logic [15:0] m, input logic [3:0] b,
                          input logic [1:0] md, input bit wb, input logic [1:0] f,
                          input bit dis, input bit cst, input bit poke, input string tag);
        logic [3:0]  ord [16];
        int          n = 0;
        int          k = 0;
        bit          waiting = 0;
        bit          wb_seen = 0;
        bit          stalled = 0;
        logic [31:0] st_addr = 0;
        logic [31:0] ld_addr = 0;
        logic [3:0]  ld_reg = 0;
        logic [31:0] base_v = exp_rf[b];
        logic [31:0] first, final_a;
        bit          bad = exp_bad(ld, m, b, md, wb, f);
        for (int i = 0; i < 16; i++) if (m[i]) begin ord[n] = 4'(i); n++; end
        case (md)
            2'd0: first = base_v;
            2'd1: first = base_v + 4;
            2'd2: first = base_v - 32'(4 * n) + 4;
            default: first = base_v - 32'(4 * n);
        endcase
        final_a = md[1] ? base_v - 32'(4 * n) : base_v + 32'(4 * n);

        @(negedge clk);
        is_load = ld; reg_mask = m; base_idx = b; addr_mode = md; wback = wb;
        enc_form = f; state_sw_dis = dis; cur_compact = cst; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (bad) begin
            #1;
            chk(err === 1'b1, {tag, " err pulse"}, 32'(err), 1);
            chk(!busy && !mem_req_valid, {tag, " no transfer"}, 32'(busy), 0);
            @(negedge clk); #1;
            chk(err === 1'b0 && !busy, {tag, " err one cycle"}, 32'(err), 0);
            return;
        end
        for (int it = 0; it < 400; it++) begin
            mem_req_ready = ($urandom % 3) != 0;
            mem_rsp_valid = waiting && (($urandom % 2) == 0);
            mem_rsp_data  = memfn(ld_addr);
            if (poke) begin
                start = (it == 2);
                reg_mask = (it == 2) ? 16'h0 : m;
            end
            #1;
            if (poke) chk(err === 1'b0, "R11 start while busy ignored", 32'(err), 0);
            if (!busy) break;
            if (stalled) chk(mem_req_valid && mem_req_addr == st_addr, "R12 stalled request held",
                             mem_req_addr, st_addr);
            stalled = mem_req_valid && !mem_req_ready;
            st_addr = mem_req_addr;
            if (mem_req_valid && mem_req_ready) begin
                chk(mem_req_reg == ord[k], "R5 register order", 32'(mem_req_reg), 32'(ord[k]));
                chk(mem_req_addr == first + 32'(4 * k), (k == 0) ? "R5 first address" : "R6 address step",
                    mem_req_addr, first + 32'(4 * k));
                chk(mem_req_write == !ld, "R5 direction", 32'(mem_req_write), 32'(!ld));
                if (!ld)
                    chk(mem_req_wdata == exp_rf[ord[k]],
                        (wb && ord[k] == b && k == 0) ? "R8 initial base stored" : "R8 store data",
                        mem_req_wdata, exp_rf[ord[k]]);
                if (ld) begin waiting = 1; ld_addr = mem_req_addr; ld_reg = ord[k]; end
                k++;
            end else if (waiting) begin
                if (mem_rsp_valid) begin
                    chk(rf_we && rf_waddr == ld_reg && rf_wdata == mem_rsp_data, "R9 load write",
                        rf_wdata, mem_rsp_data);
                    exp_rf[ld_reg] = mem_rsp_data;
                    if (ld_reg == 4'd15) begin
                        chk(br_valid && br_target == {mem_rsp_data[31:1], 1'b0}, "R10 branch target",
                            br_target, {mem_rsp_data[31:1], 1'b0});
                        chk(br_compact == (dis ? cst : mem_rsp_data[0]), "R10 branch state",
                            32'(br_compact), 32'(dis ? cst : mem_rsp_data[0]));
                    end else begin
                        chk(!br_valid, "R10 no branch", 32'(br_valid), 0);
                    end
                    waiting = 0;
                end else begin
                    chk(!rf_we, "R9 no write before response", 32'(rf_we), 0);
                end
            end else if (rf_we) begin
                chk(wb && rf_waddr == b && rf_wdata == final_a && k == n, "R7 writeback",
                    rf_wdata, final_a);
                exp_rf[b] = final_a;
                wb_seen = 1;
            end
            @(negedge clk);
        end
        mem_req_ready = 1'b0; mem_rsp_valid = 1'b0;
        chk(k == n, {tag, " R5 beat count"}, 32'(k), 32'(n));
        chk(wb_seen == wb, {tag, " R11 R7 busy through writeback"}, 32'(wb_seen), 32'(wb));
        chk(!busy, "R11 idle after operation", 32'(busy), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 16; i++) begin
            rf_mem[i] = 32'h0004_0000 + 32'(i) * 32'h0000_1000;
            exp_rf[i] = rf_mem[i];
        end
        rst = 1; start = 0; is_load = 0; reg_mask = 0; base_idx = 0; addr_mode = 0;
        wback = 0; enc_form = 0; state_sw_dis = 0; cur_compact = 0;
        mem_req_ready = 0; mem_rsp_valid = 0; mem_rsp_data = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        chk(!busy && !err && !mem_req_valid && !rf_we, "R11 reset state", 32'(busy), 0);

        run_op(1, 16'h0007, 4'd4, 2'd0, 1, 2'd0, 0, 0, 0, "R5 inc-after load");
        run_op(0, 16'h0320, 4'd6, 2'd1, 1, 2'd0, 0, 0, 0, "R5 inc-before store");
        run_op(1, 16'h0092, 4'd9, 2'd2, 1, 2'd0, 0, 0, 0, "R5 dec-after load");
        run_op(0, 16'h1878, 4'd1, 2'd3, 1, 2'd0, 0, 0, 0, "R5 dec-before store");
        run_op(0, 16'h0014, 4'd2, 2'd0, 1, 2'd0, 0, 0, 0, "R8 base lowest");
        run_op(1, 16'h8001, 4'd3, 2'd0, 0, 2'd0, 0, 1, 0, "R10 pc load");
        run_op(1, 16'h8004, 4'd5, 2'd0, 0, 2'd0, 1, 1, 0, "R10 pc load state kept");
        run_op(1, 16'h0000, 4'd3, 2'd0, 1, 2'd0, 0, 0, 0, "R1 empty mask");
        run_op(0, 16'h0003, 4'd15, 2'd0, 1, 2'd0, 0, 0, 0, "R2 base 15");
        run_op(1, 16'h2001, 4'd2, 2'd0, 1, 2'd1, 0, 0, 0, "R3 sp in list");
        run_op(0, 16'h8001, 4'd2, 2'd0, 1, 2'd1, 0, 0, 0, "R3 pc in store");
        run_op(1, 16'hC001, 4'd2, 2'd0, 1, 2'd1, 0, 0, 0, "R3 lr and pc load");
        run_op(1, 16'h8002, 4'd3, 2'd3, 0, 2'd1, 0, 0, 0, "R3 legal pc load");
        run_op(0, 16'h0101, 4'd2, 2'd0, 1, 2'd2, 0, 0, 0, "R4 high register");
        run_op(0, 16'h0011, 4'd8, 2'd0, 1, 2'd2, 0, 0, 0, "R4 high base");
        run_op(0, 16'h0011, 4'd2, 2'd1, 1, 2'd2, 0, 0, 0, "R4 wrong mode");
        run_op(0, 16'h0011, 4'd2, 2'd0, 0, 2'd2, 0, 0, 0, "R4 no writeback");
        run_op(1, 16'h00C1, 4'd3, 2'd0, 1, 2'd2, 0, 0, 0, "R4 legal short");
        run_op(0, 16'h0011, 4'd2, 2'd0, 1, 2'd3, 0, 0, 0, "R4 reserved form");
        run_op(0, 16'h0F00, 4'd2, 2'd0, 0, 2'd0, 0, 0, 1, "R11 poke");

        for (int t = 0; t < 150; t++) begin
            logic [1:0] f;
            f = (($urandom % 4) == 0) ? 2'($urandom % 4) : 2'd0;
            run_op(1'($urandom), 16'($urandom & $urandom), 4'($urandom), 2'($urandom),
                   1'($urandom), f, 1'($urandom), 1'($urandom), 0, "random");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule